// File: doc/BRIEF.md
# Byte-Wide Flash Command Sequencer

This block sits behind the bus-write port of a byte-wide flash. It watches each accepted write and checks it against the unlock patterns that guard destructive operations. All patterns open with the same two writes. The third write picks program, erase or identification mode. An erase needs a second unlock pair and then a final write that chooses between one 4 KB sector and the whole array. A completed program or erase raises a one-cycle operation pulse that carries the kind, address and data. That pulse drives an external busy/status block and the behavioural byte array kept inside this block.

Reads use a separate request port, and the response comes back one cycle later. In normal mode the response is the array byte. In identification mode it is a fixed manufacturer or device byte. The write port uses valid/ready. `wr_ready` is the inverse of `busy`, so the status block applies back-pressure for the whole internal operation. A write is taken only on a clock edge where `wr_valid` and `wr_ready` are both high. The read request has no ready: every `rd_valid` cycle is taken and answered.

The behavioural array folds the address space down to a small store. The store index is the low `MDL_SECT_W` sector bits above bit 12, followed by the low `MDL_OFF_W` address bits. The defaults are bits 13:12 and 5:0, which gives 256 bytes.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the sequencer is at its first step and in normal mode. No operation pulse is raised, and every array byte reads FFh.
- R2: Four writes trigger a program: AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h, then the target write at any address with any data. On the cycle after the target write, `op_valid` pulses for one cycle with `op_kind`=1 and the target address and data. The stored byte then becomes old AND data, so programming only clears bits.
- R3: Six writes trigger a sector erase: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address. The pulse carries `op_kind`=2, that address and 30h. Every byte whose address bits 18:12 match reads FFh afterwards, and bytes in other sectors keep their values.
- R4: The same five-write prefix followed by 10h at 5555h erases the whole array. The pulse carries `op_kind`=3, and every byte reads FFh afterwards. A 10h at any other address is a mismatch.
- R5: Command addresses 5555h and 2AAAh are matched on address bits 14:0 only. Bits 18:15 are don't-care.
- R6: AAh@5555h, 55h@2AAAh, 90h@5555h enters identification mode. In that mode, reads at 0000h and 0003h return 7Fh, reads at 0040h return 1Fh, and reads at 0001h return `DEV_CODE`. All other addresses return 00h, decoded on bits 14:0. In this mode a third write of A0h or 80h is a mismatch, so program and erase cannot start.
- R7: An F0h write at any address returns the sequencer to its first step and leaves identification mode. This applies at every step except the program target step, where F0h is ordinary data. The three-write form AAh@5555h, 55h@2AAAh, F0h@5555h therefore has the same effect.
- R8: A write that does not match the expected step aborts to the first step, and the identification mode is left unchanged. If that mismatching write is itself AAh at 5555h, it counts as the first unlock write.
- R9: While `busy` is high, `wr_ready` is low. A write presented then is not taken and has no effect on the sequence or the array.
- R10: `rd_rsp_valid` is high exactly on the cycle after a cycle with `rd_valid` high. `rd_rsp_data` reflects the mode and array contents in place before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus write offered |
| wr_ready | output | 1 | Write can be taken (low while busy) |
| wr_addr | input | 19 | Bus write address |
| wr_data | input | 8 | Bus write data |
| busy | input | 1 | Internal operation in progress, from the status block |
| rd_valid | input | 1 | Read request |
| rd_addr | input | 19 | Read address |
| rd_rsp_valid | output | 1 | Read response valid |
| rd_rsp_data | output | 8 | Read response byte |
| op_valid | output | 1 | One-cycle operation start pulse |
| op_kind | output | 2 | 1 program, 2 sector erase, 3 chip erase |
| op_addr | output | 19 | Address of the final sequence write |
| op_data | output | 8 | Data of the final sequence write |

## Verification
The bench targets the places where an unlock FSM most often goes wrong, and says what a faulty design would show in each case.
- Restart on AAh@5555h in the middle of a sequence: a design that dropped this write would ignore the program that follows.
- Upper address bits: a design that compared them would miss the commands issued at aliased addresses.
- 10h at a non-command address: if it still erased the chip, previously programmed bytes would read back as FFh.
- F0h as program data: if it were taken as an exit, the byte would stay FFh instead of reading F0h.
- Writes while busy: if they were accepted, the sequence that follows would fire an operation the model does not expect.
- Program and erase attempts in identification mode: if they were honoured, the array would change under the ID bytes.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  // Step reached in the unlock pattern
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PGM,
    ST_ERS1,
    ST_ERS2,
    ST_ERS3
  } step_e;

  // Operation kind carried on the start pulse
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  localparam logic [7:0] CODE_UNL1  = 8'hAA;
  localparam logic [7:0] CODE_UNL2  = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERASE = 8'h80;
  localparam logic [7:0] CODE_IDENT = 8'h90;
  localparam logic [7:0] CODE_EXIT  = 8'hF0;
  localparam logic [7:0] CODE_SECT  = 8'h30;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] BYTE_BLANK = 8'hFF;

endpackage

// File: rtl/fseq_cmd_fsm.sv
module fseq_cmd_fsm
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CMD_AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              id_mode,
  output logic              pgm_step,
  output logic              op_valid,
  output op_e               op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);

  localparam logic [CMD_AW-1:0] ADR_C1 = CMD_AW'(15'h5555);
  localparam logic [CMD_AW-1:0] ADR_C2 = CMD_AW'(15'h2AAA);

  step_e step, step_nx;
  logic  id_nx;
  logic  fire_nx;
  op_e   kind_nx;

  logic at_c1, at_c2, unl1_hit, unl2_hit;
  step_e restart;

  // R5: only the low CMD_AW address bits take part in command matching
  assign at_c1    = (wr_addr[CMD_AW-1:0] == ADR_C1);
  assign at_c2    = (wr_addr[CMD_AW-1:0] == ADR_C2);
  assign unl1_hit = at_c1 && (wr_data == CODE_UNL1);
  assign unl2_hit = at_c2 && (wr_data == CODE_UNL2);
  // R8: a mismatching first-unlock write re-arms the pattern
  assign restart  = unl1_hit ? ST_UNL1 : ST_IDLE;

  always_comb begin
    step_nx = step;
    id_nx   = id_mode;
    fire_nx = 1'b0;
    kind_nx = OP_NONE;
    if (wr_fire) begin
      if (step != ST_PGM && wr_data == CODE_EXIT) begin
        // R7: exit from any step except the program target write
        step_nx = ST_IDLE;
        id_nx   = 1'b0;
      end else begin
        unique case (step)
          ST_IDLE: step_nx = unl1_hit ? ST_UNL1 : ST_IDLE;
          ST_UNL1: step_nx = unl2_hit ? ST_UNL2 : restart;
          ST_UNL2: begin
            if (at_c1 && wr_data == CODE_PROG && !id_mode)       step_nx = ST_PGM;
            else if (at_c1 && wr_data == CODE_ERASE && !id_mode) step_nx = ST_ERS1;
            else if (at_c1 && wr_data == CODE_IDENT) begin
              step_nx = ST_IDLE;
              id_nx   = 1'b1;
            end else step_nx = restart;
          end
          ST_PGM: begin
            step_nx = ST_IDLE;
            fire_nx = 1'b1;
            kind_nx = OP_PROG;
          end
          ST_ERS1: step_nx = unl1_hit ? ST_ERS2 : ST_IDLE;
          ST_ERS2: step_nx = unl2_hit ? ST_ERS3 : restart;
          ST_ERS3: begin
            if (wr_data == CODE_SECT) begin
              step_nx = ST_IDLE;
              fire_nx = 1'b1;
              kind_nx = OP_SECT;
            end else if (at_c1 && wr_data == CODE_CHIP) begin
              step_nx = ST_IDLE;
              fire_nx = 1'b1;
              kind_nx = OP_CHIP;
            end else step_nx = restart;
          end
          default: step_nx = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step     <= ST_IDLE;
      id_mode  <= 1'b0;
      op_valid <= 1'b0;
      op_kind  <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      step     <= step_nx;
      id_mode  <= id_nx;
      op_valid <= fire_nx;
      if (fire_nx) begin
        op_kind <= kind_nx;
        op_addr <= wr_addr;
        op_data <= wr_data;
      end
    end
  end

  assign pgm_step = (step == ST_PGM);

endmodule

// File: rtl/fseq_id_rom.sv
module fseq_id_rom #(
  parameter int         CMD_AW   = 15,
  parameter logic [7:0] DEV_CODE = 8'hC4
) (
  input  logic [CMD_AW-1:0] addr,
  output logic [7:0]        id_byte
);

  // R6: identification bytes decoded on the command-address bits
  always_comb begin
    unique case (addr)
      CMD_AW'(0), CMD_AW'(3): id_byte = 8'h7F;
      CMD_AW'('h40):          id_byte = 8'h1F;
      CMD_AW'(1):             id_byte = DEV_CODE;
      default:                id_byte = 8'h00;
    endcase
  end

endmodule

// File: rtl/fseq_array_mdl.sv
module fseq_array_mdl
  import fseq_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int SECT_LSB   = 12,
  parameter int MDL_SECT_W = 2,
  parameter int MDL_OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  op_e               op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte
);

  localparam int IDX_W = MDL_SECT_W + MDL_OFF_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]      op_idx, rd_idx;
  logic [MDL_SECT_W-1:0] op_sect;
  logic [7:0]            cell_q [DEPTH];
  logic                  unused_hi;

  assign op_idx    = {op_addr[SECT_LSB +: MDL_SECT_W], op_addr[MDL_OFF_W-1:0]};
  assign rd_idx    = {rd_addr[SECT_LSB +: MDL_SECT_W], rd_addr[MDL_OFF_W-1:0]};
  assign op_sect   = op_addr[SECT_LSB +: MDL_SECT_W];
  assign unused_hi = ^{op_addr, rd_addr};

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam int unsigned CELL_SECT = i / (1 << MDL_OFF_W);
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= BYTE_BLANK;                       // R1
      end else if (op_valid) begin
        unique case (op_kind)
          OP_PROG: if (op_idx == IDX_W'(i)) q <= q & op_data;                       // R2
          OP_SECT: if (op_sect == CELL_SECT[MDL_SECT_W-1:0]) q <= BYTE_BLANK;       // R3
          OP_CHIP: q <= BYTE_BLANK;                                                 // R4
          default: q <= q;
        endcase
      end
    end
    assign cell_q[i] = q;
  end

  assign rd_byte = cell_q[rd_idx];

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fseq_pkg::*;
#(
  parameter int         ADDR_W     = 19,
  parameter int         CMD_AW     = 15,
  parameter int         SECT_LSB   = 12,
  parameter int         MDL_SECT_W = 2,
  parameter int         MDL_OFF_W  = 6,
  parameter logic [7:0] DEV_CODE   = 8'hC4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_rsp_valid,
  output logic [7:0]        rd_rsp_data,
  output logic              op_valid,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);

  logic       wr_fire;
  logic       id_mode;
  logic       pgm_step;
  op_e        kind_q;
  logic [7:0] id_byte;
  logic [7:0] arr_byte;

  // R9: the status block holds writes off for the whole operation
  assign wr_ready = !busy;
  assign wr_fire  = wr_valid && wr_ready;
  assign op_kind  = kind_q;

  fseq_cmd_fsm #(
    .ADDR_W (ADDR_W),
    .CMD_AW (CMD_AW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .id_mode  (id_mode),
    .pgm_step (pgm_step),
    .op_valid (op_valid),
    .op_kind  (kind_q),
    .op_addr  (op_addr),
    .op_data  (op_data)
  );

  fseq_id_rom #(
    .CMD_AW   (CMD_AW),
    .DEV_CODE (DEV_CODE)
  ) u_id (
    .addr    (rd_addr[CMD_AW-1:0]),
    .id_byte (id_byte)
  );

  fseq_array_mdl #(
    .ADDR_W     (ADDR_W),
    .SECT_LSB   (SECT_LSB),
    .MDL_SECT_W (MDL_SECT_W),
    .MDL_OFF_W  (MDL_OFF_W)
  ) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_kind  (kind_q),
    .op_addr  (op_addr),
    .op_data  (op_data),
    .rd_addr  (rd_addr),
    .rd_byte  (arr_byte)
  );

  // R10: registered read response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
    end else begin
      rd_rsp_valid <= rd_valid;
      if (rd_valid) rd_rsp_data <= id_mode ? id_byte : arr_byte;
    end
  end

endmodule

module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_data,
  input logic       busy,
  input logic       rd_valid,
  input logic       rd_rsp_valid,
  input logic       op_valid,
  input logic [1:0] op_kind,
  input logic       id_mode,
  input logic       pgm_step
);

  // R2
  op_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  // R3
  op_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(wr_valid && wr_ready));

  // R4
  op_kind_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> op_kind != 2'd0);

  // R9
  busy_no_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_valid) |=> !op_valid);

  // R10
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_rsp_valid);

  // R10
  rsp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid |-> $past(rd_valid));

  // R6
  id_entry_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(wr_data == 8'h90));

  // R7
  exit_clears_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_data == 8'hF0 && !pgm_step) |=> !id_mode);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_data      (wr_data),
  .busy         (busy),
  .rd_valid     (rd_valid),
  .rd_rsp_valid (rd_rsp_valid),
  .op_valid     (op_valid),
  .op_kind      (op_kind),
  .id_mode      (id_mode),
  .pgm_step     (pgm_step)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

  localparam int CLK_T = 10;
  localparam logic [7:0] DEV = 8'hC4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic        rd_valid = 1'b0;
  logic [18:0] rd_addr = '0;
  logic        rd_rsp_valid;
  logic [7:0]  rd_rsp_data;
  logic        op_valid;
  logic [1:0]  op_kind;
  logic [18:0] op_addr;
  logic [7:0]  op_data;

  always #(CLK_T/2) clk = ~clk;

  flash_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  mmem [256];
  logic [18:0] ha [$];
  logic [7:0]  hd [$];
  bit          mid;
  bit          e_op;
  int          e_kind;
  logic [18:0] e_addr;
  logic [7:0]  e_data;
  bit          e_rv;
  logic [7:0]  e_rd;

  function automatic int midx(logic [18:0] a);
    return {a[13:12], a[5:0]};
  endfunction

  function automatic logic [7:0] id_byte(logic [18:0] a);
    case (a[14:0])
      15'h0000, 15'h0003: return 8'h7F;
      15'h0040:           return 8'h1F;
      15'h0001:           return DEV;
      default:            return 8'h00;
    endcase
  endfunction

  // patterns: 0 program, 1 sector erase, 2 chip erase, 3 id entry
  function automatic int plen(int p);
    return (p == 0) ? 4 : (p == 3) ? 3 : 6;
  endfunction

  function automatic bit pat_ok(int p, int pos, logic [18:0] a, logic [7:0] d);
    bit c1 = (a[14:0] == 15'h5555);
    bit c2 = (a[14:0] == 15'h2AAA);
    case (pos)
      0: return c1 && d == 8'hAA;
      1: return c2 && d == 8'h55;
      2: return c1 && d == ((p == 0) ? 8'hA0 : (p == 3) ? 8'h90 : 8'h80);
      3: return (p == 0) ? 1'b1 : (c1 && d == 8'hAA);
      4: return c2 && d == 8'h55;
      5: return (p == 1) ? (d == 8'h30) : (c1 && d == 8'h10);
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit hist_match(int p, int n);
    for (int k = 0; k < n; k++)
      if (!pat_ok(p, k, ha[k], hd[k])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit p_en(int p);
    return (p == 3) || !mid;
  endfunction

  task automatic proc_write(logic [18:0] a, logic [7:0] d);
    bit slot = !mid && ha.size() == 3 && hist_match(0, 3);
    bit alive = 1'b0;
    if (d == 8'hF0 && !slot) begin
      ha.delete(); hd.delete(); mid = 1'b0;
      return;
    end
    ha.push_back(a); hd.push_back(d);
    for (int p = 0; p < 4; p++) begin
      if (p_en(p) && ha.size() == plen(p) && hist_match(p, plen(p))) begin
        if (p == 3) mid = 1'b1;
        else begin
          e_op = 1'b1; e_kind = p + 1; e_addr = a; e_data = d;
        end
        ha.delete(); hd.delete();
        return;
      end
    end
    for (int p = 0; p < 4; p++)
      if (p_en(p) && ha.size() < plen(p) && hist_match(p, ha.size())) alive = 1'b1;
    if (!alive) begin
      ha.delete(); hd.delete();
      if (a[14:0] == 15'h5555 && d == 8'hAA) begin
        ha.push_back(a); hd.push_back(d);
      end
    end
  endtask

  task automatic apply_op();
    if (e_kind == 1) mmem[midx(e_addr)] = mmem[midx(e_addr)] & e_data;
    else if (e_kind == 2) begin
      for (int i = 0; i < 256; i++) if ((i >> 6) == int'(e_addr[13:12])) mmem[i] = 8'hFF;
    end else if (e_kind == 3) begin
      for (int i = 0; i < 256; i++) mmem[i] = 8'hFF;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mmem[i] = 8'hFF;
      ha.delete(); hd.delete();
      mid = 1'b0; e_op = 1'b0; e_rv = 1'b0;
    end else begin
      e_rv = rd_valid;
      if (rd_valid) e_rd = mid ? id_byte(rd_addr) : mmem[midx(rd_addr)];
      if (e_op) apply_op();
      e_op = 1'b0;
      if (wr_valid && !busy) proc_write(wr_addr, wr_data);
    end
    #(CLK_T/4);
    chk(wr_ready === !busy, "wr_ready", wr_ready, !busy);
    chk(rd_rsp_valid === e_rv, "rd_rsp_valid", rd_rsp_valid, e_rv);
    if (e_rv) chk(rd_rsp_data === e_rd, "rd_rsp_data", rd_rsp_data, e_rd);
    chk(op_valid === e_op, "op_valid", op_valid, e_op);
    if (e_op) begin
      chk(op_kind === 2'(e_kind), "op_kind", op_kind, e_kind);
      chk(op_addr === e_addr, "op_addr", op_addr, e_addr);
      chk(op_data === e_data, "op_data", op_data, e_data);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic expect_rd(input logic [18:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rd_rsp_data === exp, $sformatf("read @%0h", a), rd_rsp_data, exp);
  endtask

  task automatic prog(input logic [18:0] a, input logic [7:0] d);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(a, d);
  endtask

  task automatic erase(input logic [18:0] a, input logic [7:0] code);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h80);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(a, code);
  endtask

  task automatic id_enter();
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h90);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    expect_rd(19'h00000, 8'hFF);
    expect_rd(19'h03021, 8'hFF);

    cur_req = "R2";
    prog(19'h00005, 8'h5A);
    expect_rd(19'h00005, 8'h5A);
    prog(19'h00005, 8'h0F);
    expect_rd(19'h00005, 8'h0A);

    cur_req = "R5";
    wr(19'h7D555, 8'hAA); wr(19'h7AAAA, 8'h55); wr(19'h4D555, 8'hA0); wr(19'h01010, 8'h33);
    expect_rd(19'h01010, 8'h33);

    cur_req = "R3";
    prog(19'h01020, 8'h12);
    prog(19'h00021, 8'h34);
    erase(19'h01000, 8'h30);
    expect_rd(19'h01020, 8'hFF);
    expect_rd(19'h01010, 8'hFF);
    expect_rd(19'h00021, 8'h34);

    cur_req = "R4";
    erase(19'h01234, 8'h10);
    expect_rd(19'h00021, 8'h34);
    erase(19'h05555, 8'h10);
    expect_rd(19'h00021, 8'hFF);
    expect_rd(19'h00005, 8'hFF);

    cur_req = "R6";
    id_enter();
    expect_rd(19'h00000, 8'h7F);
    expect_rd(19'h00003, 8'h7F);
    expect_rd(19'h00040, 8'h1F);
    expect_rd(19'h00001, DEV);
    expect_rd(19'h00002, 8'h00);
    prog(19'h00002, 8'h00);
    expect_rd(19'h00000, 8'h7F);

    cur_req = "R7";
    wr(19'h12345, 8'hF0);
    expect_rd(19'h00002, 8'hFF);
    id_enter();
    expect_rd(19'h00001, DEV);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hF0);
    expect_rd(19'h00001, 8'hFF);
    prog(19'h00007, 8'hF0);
    expect_rd(19'h00007, 8'hF0);

    cur_req = "R8";
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(19'h00009, 8'h81);
    expect_rd(19'h00009, 8'h81);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h12); wr(19'h05555, 8'hA0); wr(19'h0000A, 8'h00);
    expect_rd(19'h0000A, 8'hFF);

    cur_req = "R9";
    @(negedge clk); busy = 1'b1;
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
    @(negedge clk); busy = 1'b0;
    wr(19'h05555, 8'hA0); wr(19'h0000B, 8'h00);
    expect_rd(19'h0000B, 8'hFF);

    cur_req = "R10";
    @(negedge clk); rd_valid = 1'b1; rd_addr = 19'h00007;
    repeat (3) @(negedge clk);
    rd_valid = 1'b0;
    repeat (3) @(negedge clk);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL %s watchdog actual=%0d expected=%0d", cur_req, 20000, 0);
    finish_run();
  end

endmodule